// File: doc/BRIEF.md
# Dual-Port Audio Interrupt Aggregator

This block gathers the service requests of two audio ports into one interrupt line. Each port has a transmit and a receive direction, which gives four request inputs. A rising edge on a request sets a sticky bit in a status register. A source drives the shared interrupt only when two independent enable registers both allow it, so two software layers can gate the same source without touching each other's settings.

A small register interface gives access to the status register, the two enable registers, a clock-release register and a control register. The status register clears by writing zeros. The control register holds an active-low run bit that keeps every other register cleared while it is low. It also holds an acknowledge bit that the handler toggles low and then high. Each 0-to-1 transition of that bit produces a one-cycle acknowledge pulse. The clock-release register drives one enable output for each port.

Top module: `audio_irq_agg`

## Requirements
- R1: A rising edge on a request input sets its status bit: `svc_req[0]` (port A transmit) sets bit 0, `svc_req[1]` (port A receive) sets bit 4, `svc_req[2]` (port B transmit) sets bit 8 and `svc_req[3]` (port B receive) sets bit 12. The bit is set one clock after the edge is sampled. A request that stays high does not set the bit again after it has been cleared.
- R2: A status bit latches even when its source is disabled in either enable register. When the source is later enabled, `irq` rises on the clock after that write.
- R3: Both enable registers use the status bit positions. A status bit drives `irq` only if the same bit is set in enable register 1 and in enable register 2.
- R4: `irq` is a registered level. It is high in the cycle after any status bit is set in both enable registers, and it is low in the cycle after no such bit remains.
- R5: A write to the status register clears each status bit whose write-data bit is 0 and keeps each bit whose write-data bit is 1. Writing zero clears all bits.
- R6: When a request edge and a status write that clears the same bit fall in the same cycle, the bit ends up set.
- R7: While bit 0 of the control register (run, active low) is 0, the status, enable and clock-release registers and `irq` are held at zero, and requests are ignored. A hardware reset leaves run at 0.
- R8: Writing bit 4 of the control register from 0 to 1 gives a one-cycle `irq_ack` pulse in the cycle after the write. Writing 1 when the bit is already 1 gives no pulse.
- R9: In the clock-release register, bit 0 drives `port_clk_en[0]` (port A) and bit 4 drives `port_clk_en[1]` (port B).
- R10: The register addresses are 0 status, 1 enable register 1, 2 enable register 2, 3 clock release and 4 control. Bits outside the defined positions read as zero. Other addresses read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| svc_req | input | 4 | Service requests {B rx, B tx, A rx, A tx} |
| irq | output | 1 | Aggregated interrupt |
| port_clk_en | output | 2 | Clock release for port B (bit 1) and port A (bit 0) |
| irq_ack | output | 1 | One-cycle acknowledge pulse |

## Verification
A new request edge and a status write that clears bits can land in the same cycle. This is the case where a handler clears its status while another request arrives. The bench provokes it by raising the port A transmit request in the same cycle as a write of zero to the status register. It judges the result by reading the status back: bit 0 must be set and all previously latched bits must be gone.

// File: rtl/audio_irq_agg.sv
module audio_irq_agg #(
  parameter int DW      = 16,
  parameter int AW      = 3,
  parameter int NSRC    = 4,
  parameter int SPACING = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [NSRC-1:0] svc_req,
  output logic          irq,
  output logic [1:0]    port_clk_en,
  output logic          irq_ack
);

  localparam int RUN_BIT = 0;
  localparam int ACK_BIT = 4;
  localparam int CLKA_BIT = 0;
  localparam int CLKB_BIT = 4;

  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_EN1  = AW'(1);
  localparam logic [AW-1:0] A_EN2  = AW'(2);
  localparam logic [AW-1:0] A_CLK  = AW'(3);
  localparam logic [AW-1:0] A_CTL  = AW'(4);

  function automatic logic [DW-1:0] spread_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[i*SPACING] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] LIVE     = spread_mask();
  localparam logic [DW-1:0] CLK_LIVE = (DW'(1) << CLKA_BIT) | (DW'(1) << CLKB_BIT);
  localparam logic [DW-1:0] CTL_LIVE = (DW'(1) << RUN_BIT) | (DW'(1) << ACK_BIT);

  logic [DW-1:0]   stat, en1, en2, clkr, ctl;
  logic [NSRC-1:0] req_q;
  logic [DW-1:0]   rise_bits;
  logic            irq_q, ack_q;

  wire soft_run = ctl[RUN_BIT];
  wire wr_stat  = reg_we && reg_addr == A_STAT;
  wire wr_en1   = reg_we && reg_addr == A_EN1;
  wire wr_en2   = reg_we && reg_addr == A_EN2;
  wire wr_clk   = reg_we && reg_addr == A_CLK;
  wire wr_ctl   = reg_we && reg_addr == A_CTL;
  wire [DW-1:0] armed = stat & en1 & en2;

  always_comb begin
    rise_bits = '0;
    for (int i = 0; i < NSRC; i++)
      rise_bits[i*SPACING] = svc_req[i] & ~req_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= svc_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      en1  <= '0;
      en2  <= '0;
      clkr <= '0;
    end else if (!soft_run) begin
      stat <= '0;
      en1  <= '0;
      en2  <= '0;
      clkr <= '0;
    end else begin
      stat <= ((wr_stat ? (stat & reg_wdata) : stat) | rise_bits) & LIVE;
      if (wr_en1) en1  <= reg_wdata & LIVE;
      if (wr_en2) en2  <= reg_wdata & LIVE;
      if (wr_clk) clkr <= reg_wdata & CLK_LIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= '0;
      ack_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (wr_ctl) ctl <= reg_wdata & CTL_LIVE;
      ack_q <= wr_ctl & reg_wdata[ACK_BIT] & ~ctl[ACK_BIT];
      irq_q <= soft_run & (|armed);
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = stat;
      A_EN1:   reg_rdata = en1;
      A_EN2:   reg_rdata = en2;
      A_CLK:   reg_rdata = clkr;
      A_CTL:   reg_rdata = ctl;
      default: reg_rdata = '0;
    endcase
  end

  assign irq         = irq_q;
  assign irq_ack     = ack_q;
  assign port_clk_en = {clkr[CLKB_BIT], clkr[CLKA_BIT]};

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_run && |armed) |=> irq);

  // R3
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|armed) |=> !irq);

  // R7
  soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_run |=> (stat == '0 && en1 == '0 && en2 == '0 && clkr == '0 && !irq));

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      // R1
      latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_run && svc_req[g] && !req_q[g]) |=> stat[g*SPACING]);
    end
  endgenerate

endmodule

// File: tb/audio_irq_agg_test.sv
module audio_irq_agg_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [3:0]  svc_req;
  logic        irq;
  logic [1:0]  port_clk_en;
  logic        irq_ack;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  audio_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .svc_req(svc_req),
    .irq(irq), .port_clk_en(port_clk_en), .irq_ack(irq_ack)
  );

  // {we, addr, wdata, req, exp_irq, exp_rdata}
  localparam int NV = 23;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 3'd1, 16'h1111, 4'b0000, 1'b0, 16'h1111}, // R10 enable 1
    {1'b0, 3'd0, 16'h0000, 4'b0001, 1'b0, 16'h0001}, // R1 A tx
    {1'b0, 3'd0, 16'h0000, 4'b0001, 1'b0, 16'h0001}, // R3 enable 2 off
    {1'b1, 3'd2, 16'h0001, 4'b0001, 1'b0, 16'h0001}, // R2 enable late
    {1'b0, 3'd0, 16'h0000, 4'b0001, 1'b1, 16'h0001}, // R2 irq at once
    {1'b1, 3'd0, 16'h0000, 4'b0001, 1'b1, 16'h0000}, // R5 clear all
    {1'b0, 3'd0, 16'h0000, 4'b0000, 1'b0, 16'h0000}, // R4 irq falls, R1 held req
    {1'b0, 3'd0, 16'h0000, 4'b0010, 1'b0, 16'h0010}, // R1 A rx
    {1'b0, 3'd0, 16'h0000, 4'b0010, 1'b0, 16'h0010}, // R3
    {1'b1, 3'd2, 16'h1111, 4'b0000, 1'b0, 16'h1111}, // R10 enable 2
    {1'b0, 3'd0, 16'h0000, 4'b0000, 1'b1, 16'h0010}, // R4
    {1'b0, 3'd0, 16'h0000, 4'b0100, 1'b1, 16'h0110}, // R1 B tx
    {1'b0, 3'd0, 16'h0000, 4'b1100, 1'b1, 16'h1110}, // R1 B rx
    {1'b1, 3'd0, 16'h1100, 4'b1100, 1'b1, 16'h1100}, // R5 partial clear
    {1'b1, 3'd1, 16'h0100, 4'b0000, 1'b1, 16'h0100}, // R3
    {1'b0, 3'd0, 16'h0000, 4'b0000, 1'b1, 16'h1100}, // R3 bit 8 in both
    {1'b1, 3'd0, 16'h1000, 4'b0000, 1'b1, 16'h1000}, // R5
    {1'b0, 3'd0, 16'h0000, 4'b0000, 1'b0, 16'h1000}, // R3 bit 12 gated
    {1'b1, 3'd0, 16'h0000, 4'b0001, 1'b0, 16'h0001}, // R6 set wins
    {1'b0, 3'd0, 16'h0000, 4'b0001, 1'b0, 16'h0001}, // R6
    {1'b1, 3'd3, 16'hFFFF, 4'b0000, 1'b0, 16'h0011}, // R9 R10
    {1'b1, 3'd5, 16'hFFFF, 4'b0000, 1'b0, 16'h0000}, // R10 unmapped
    {1'b0, 3'd1, 16'h0000, 4'b0000, 1'b0, 16'h0100}  // R10 write ignored
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [2:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; svc_req = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R7 reset irq", 16'(irq), 16'h0);
    check("R8 reset ack", 16'(irq_ack), 16'h0);
    check("R9 reset clk", 16'(port_clk_en), 16'h0);
    rd_check("R7 reset run low", 3'd4, 16'h0000);

    svc_req = 4'b0001;
    @(negedge clk);
    rd_check("R7 request ignored in reset", 3'd0, 16'h0000);
    svc_req = 4'b0000;
    @(negedge clk);

    wr(3'd4, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      reg_we    = VEC[i][40];
      reg_addr  = VEC[i][39:37];
      reg_wdata = VEC[i][36:21];
      svc_req   = VEC[i][20:17];
      @(negedge clk);
      check($sformatf("vector %0d rdata", i), reg_rdata, VEC[i][15:0]);
      check($sformatf("vector %0d irq", i), 16'(irq), 16'(VEC[i][16]));
    end
    reg_we = 1'b0;

    check("R9 clock release", 16'(port_clk_en), 16'h3);

    // R8 acknowledge edge
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 16'h0011;
    @(negedge clk);
    reg_we = 1'b0;
    check("R8 ack pulse", 16'(irq_ack), 16'h1);
    @(negedge clk);
    check("R8 ack one cycle", 16'(irq_ack), 16'h0);
    wr(3'd4, 16'h0011);
    check("R8 no pulse when already set", 16'(irq_ack), 16'h0);

    // R7 soft reset hold
    wr(3'd4, 16'h0010);
    svc_req = 4'b1111;
    @(negedge clk);
    @(negedge clk);
    rd_check("R7 status held", 3'd0, 16'h0000);
    rd_check("R7 enable held", 3'd1, 16'h0000);
    check("R7 clock held", 16'(port_clk_en), 16'h0);
    check("R7 irq held", 16'(irq), 16'h0);

    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 16'h0011;
    @(negedge clk);
    reg_we = 1'b0;
    check("R8 release no pulse", 16'(irq_ack), 16'h0);
    @(negedge clk);
    rd_check("R1 held level no set", 3'd0, 16'h0000);
    svc_req = 4'b0000;
    @(negedge clk);
    svc_req = 4'b1000;
    @(negedge clk);
    rd_check("R1 B rx after release", 3'd0, 16'h1000);

    finish_run();
  end

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule